// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This block is the memory and sequencing core of a non-blocking time-slot switch. It serves a small set of TDM streams that have already been converted to one parallel byte per channel. In each clock cycle one channel slot is served. Every input stream offers its byte for that slot, and the byte is stored in a paged data store. In the same cycle every output stream reads its own connection entry for that slot and produces one byte and one output-enable bit. These appear at the ports one cycle later.

A connection entry can do one of two things. It can name an input stream and channel whose byte is fetched, with either a one-frame constant delay or the lowest delay available. It can also hold a fixed byte from the processor that is repeated every frame. The same entry sets that channel's three-state and loopback behaviour. A frame pulse restarts the channel count and swaps the two data pages. A small processor port writes and reads connection entries and reads the data store.

Top module: `tsi_switch_core`

## Requirements
- R1: A high `frame_sync` makes the current cycle channel 0. Each later cycle advances the channel by one, and after channel NCHAN-1 the count returns to 0 even without a frame pulse.
- R2: In every cycle the byte of input stream s is stored for channel k = current channel. A processor data read at address s*NCHAN+k (cpu_sel=1) returns, one cycle later, the byte of the last completed frame.
- R3: Connection entry layout: bits [7:0] payload, bit 8 and bit 9 the mode pair (m0, m1), bit 10 variable delay, bit 11 loopback. In switched mode (mode pair not 01 and not 11) with bit 10 clear, output stream o in channel c carries the byte that input stream payload[4:3] received in channel payload[2:0] during the previous frame. It appears one cycle after channel c is served.
- R4: With bit 10 set, the source byte is taken from the current frame when the source channel is lower than c, and from the previous frame otherwise.
- R5: Any number of output channels may name the same input channel, and each of them receives that byte.
- R6: Mode pair m1m0=01 sends payload [7:0] in that channel every frame.
- R7: Mode pair m1m0=11 turns the channel off: tx_oe is 0 and the byte is 0.
- R8: When oe_pin=0 and out_stby=0, every output is off. In every other combination the per-channel entries decide.
- R9: Bit 11 set (and the channel not off) sends the byte that the same-numbered input stream presents in the same cycle. This takes priority over processor and switched sources.
- R10: A processor write (cpu_sel=0, address o*NCHAN+c) changes the entry from the next time that channel is served. A processor read returns the whole 12-bit entry one cycle later.
- R11: Processor writes with cpu_sel=1 do not change the data store.
- R12: After reset every entry is 0x300 (off), the data store holds zeros, and all outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame pulse, marks channel 0 |
| rx_data | input | NSTRM*DW | Input bytes, stream s at [s*DW +: DW] |
| oe_pin | input | 1 | Global output enable pin |
| out_stby | input | 1 | Output standby control bit |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_sel | input | 1 | 0 connection entries, 1 data store |
| cpu_addr | input | AW | stream*NCHAN + channel |
| cpu_wdata | input | EW | Entry to write |
| cpu_rdata | output | EW | Read result, registered |
| tx_data | output | NSTRM*DW | Output bytes, stream o at [o*DW +: DW] |
| tx_oe | output | NSTRM | Per-stream output enable |

## Verification
The bench builds the core with its defaults: four streams, eight channels and byte-wide data, which gives 32 connection entries and a 5-bit address. At this size it is practical to write every entry for each configuration and to check every output channel of every stream over whole frames. Input bytes come from a formula in the frame number, stream and channel, so the bench knows the previous and the current frame for any source. This makes the split between constant and variable delay visible in each channel, including the source equal to destination case.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int unsigned CTL_W = 4;

   // mode pair {m1, m0}
   typedef enum logic [1:0] {
      SRC_SWITCH     = 2'b00,
      SRC_PROC       = 2'b01,
      SRC_SWITCH_ALT = 2'b10,
      SRC_OFF        = 2'b11
   } src_mode_e;

   typedef struct packed {
      logic      loop;
      logic      vdly;
      src_mode_e mode;
   } chan_ctl_t;

   localparam logic [CTL_W-1:0] CTL_RESET = 4'b0011;
endpackage

// File: rtl/tsi_slot_seq.sv
module tsi_slot_seq #(
   parameter int NCHAN = 8,
   localparam int CW = $clog2(NCHAN)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_sync,
   output logic [CW-1:0] slot,
   output logic          wpage
);
   logic [CW-1:0] slot_q;
   logic          page_q;

   always_comb begin
      if (frame_sync)                         slot = '0;
      else if (slot_q == CW'(NCHAN-1))        slot = '0;
      else                                    slot = slot_q + 1'b1;
      wpage = frame_sync ? ~page_q : page_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= CW'(NCHAN-1);
         page_q <= 1'b0;
      end else begin
         slot_q <= slot;
         page_q <= wpage;
      end
   end

   a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> slot_q == '0);
   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_sync && slot_q == CW'(NCHAN-1)) |=> slot_q == '0);
   a_r3_page_swap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> page_q != $past(page_q));
   a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync |=> $stable(page_q));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
   parameter int NSTRM = 4,
   parameter int NCHAN = 8,
   parameter int DW    = 8,
   parameter int NRD   = 5,
   localparam int SW    = $clog2(NSTRM),
   localparam int CW    = $clog2(NCHAN),
   localparam int AW    = SW + CW,
   localparam int DEPTH = NSTRM * NCHAN
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_page,
   input  logic [CW-1:0]       wr_chan,
   input  logic [NSTRM*DW-1:0] wr_bytes,
   input  logic                rd_page [NRD],
   input  logic [AW-1:0]       rd_addr [NRD],
   output logic [DW-1:0]       rd_data [NRD]
);
   logic [DW-1:0] store [2][DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 2; p++)
            for (int a = 0; a < DEPTH; a++)
               store[p][a] <= '0;
      end else begin
         for (int s = 0; s < NSTRM; s++)
            store[wr_page][{SW'(s), wr_chan}] <= wr_bytes[s*DW +: DW];
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r] = store[rd_page[r]][rd_addr[r]];
   end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
   parameter int NSTRM = 4,
   parameter int NCHAN = 8,
   parameter int EW    = 12,
   parameter logic [EW-1:0] RST_ENTRY = '0,
   localparam int SW    = $clog2(NSTRM),
   localparam int CW    = $clog2(NCHAN),
   localparam int AW    = SW + CW,
   localparam int DEPTH = NSTRM * NCHAN
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [EW-1:0] wr_data,
   input  logic [CW-1:0] slot,
   output logic [EW-1:0] lane_entry [NSTRM],
   input  logic [AW-1:0] cpu_addr,
   output logic [EW-1:0] cpu_entry
);
   logic [EW-1:0] ent [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) ent[a] <= RST_ENTRY;
      end else if (wr_en) begin
         ent[wr_addr] <= wr_data;
      end
   end

   for (genvar o = 0; o < NSTRM; o++) begin : g_lane_rd
      assign lane_entry[o] = ent[{SW'(o), slot}];
   end

   assign cpu_entry = ent[cpu_addr];
endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
   import tsi_pkg::*;
#(
   parameter int NSTRM = 4,
   parameter int NCHAN = 8,
   parameter int DW    = 8,
   localparam int SW = $clog2(NSTRM),
   localparam int CW = $clog2(NCHAN),
   localparam int AW = SW + CW,
   localparam int EW = DW + CTL_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [EW-1:0] entry,
   input  logic [CW-1:0] slot,
   input  logic          wpage,
   input  logic          glob_off,
   input  logic [DW-1:0] rx_own,
   output logic          rd_page,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic [DW-1:0] tx_byte,
   output logic          tx_oe
);
   chan_ctl_t     ctl;
   logic [DW-1:0] payload;
   logic [CW-1:0] src_chan;
   logic          fresh;
   logic          off;
   logic [DW-1:0] pick;

   assign ctl      = chan_ctl_t'(entry[EW-1:DW]);
   assign payload  = entry[DW-1:0];
   assign src_chan = payload[CW-1:0];
   assign rd_addr  = payload[AW-1:0];

   // source already written in this frame only if its channel came earlier
   assign fresh   = ctl.vdly && (src_chan < slot);
   assign rd_page = fresh ? wpage : ~wpage;
   assign off     = glob_off || (ctl.mode == SRC_OFF);

   always_comb begin
      if (off)                        pick = '0;
      else if (ctl.loop)              pick = rx_own;
      else if (ctl.mode == SRC_PROC)  pick = payload;
      else                            pick = rd_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_byte <= '0;
         tx_oe   <= 1'b0;
      end else begin
         tx_byte <= pick;
         tx_oe   <= ~off;
      end
   end

   a_r7_chan_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.mode == SRC_OFF) |=> (!tx_oe && tx_byte == '0));
   a_r9_loop: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_off && ctl.loop && ctl.mode != SRC_OFF) |=> (tx_oe && tx_byte == $past(rx_own)));
   a_r6_proc: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_off && !ctl.loop && ctl.mode == SRC_PROC) |=> tx_byte == $past(payload));
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
   import tsi_pkg::*;
#(
   parameter int NSTRM = 4,
   parameter int NCHAN = 8,
   parameter int DW    = 8,
   localparam int SW  = $clog2(NSTRM),
   localparam int CW  = $clog2(NCHAN),
   localparam int AW  = SW + CW,
   localparam int EW  = DW + CTL_W,
   localparam int NRD = NSTRM + 1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_sync,
   input  logic [NSTRM*DW-1:0] rx_data,
   input  logic                oe_pin,
   input  logic                out_stby,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic                cpu_sel,
   input  logic [AW-1:0]       cpu_addr,
   input  logic [EW-1:0]       cpu_wdata,
   output logic [EW-1:0]       cpu_rdata,
   output logic [NSTRM*DW-1:0] tx_data,
   output logic [NSTRM-1:0]    tx_oe
);
   // elaboration-time parameter checks
   if (NSTRM < 2 || (1 << SW) != NSTRM) begin : g_bad_nstrm
      $error("NSTRM must be a power of two, at least 2");
   end
   if (NCHAN < 2 || (1 << CW) != NCHAN) begin : g_bad_nchan
      $error("NCHAN must be a power of two, at least 2");
   end
   if (AW > DW) begin : g_bad_dw
      $error("payload too narrow for a stream/channel pointer");
   end

   localparam logic [EW-1:0] RST_ENTRY = {CTL_RESET, {DW{1'b0}}};

   logic [CW-1:0] slot;
   logic          wpage;
   logic          glob_off;
   logic [EW-1:0] lane_entry [NSTRM];
   logic [EW-1:0] cpu_entry;
   logic          rd_page [NRD];
   logic [AW-1:0] rd_addr [NRD];
   logic [DW-1:0] rd_data [NRD];

   assign glob_off = !oe_pin && !out_stby;

   tsi_slot_seq #(.NCHAN(NCHAN)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_sync (frame_sync),
      .slot       (slot),
      .wpage      (wpage)
   );

   tsi_data_mem #(.NSTRM(NSTRM), .NCHAN(NCHAN), .DW(DW), .NRD(NRD)) dmem_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_page  (wpage),
      .wr_chan  (slot),
      .wr_bytes (rx_data),
      .rd_page  (rd_page),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   tsi_conn_mem #(.NSTRM(NSTRM), .NCHAN(NCHAN), .EW(EW), .RST_ENTRY(RST_ENTRY)) cmem_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cpu_req && cpu_we && !cpu_sel),
      .wr_addr    (cpu_addr),
      .wr_data    (cpu_wdata),
      .slot       (slot),
      .lane_entry (lane_entry),
      .cpu_addr   (cpu_addr),
      .cpu_entry  (cpu_entry)
   );

   for (genvar o = 0; o < NSTRM; o++) begin : g_lane
      tsi_out_lane #(.NSTRM(NSTRM), .NCHAN(NCHAN), .DW(DW)) lane_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .entry    (lane_entry[o]),
         .slot     (slot),
         .wpage    (wpage),
         .glob_off (glob_off),
         .rx_own   (rx_data[o*DW +: DW]),
         .rd_page  (rd_page[o]),
         .rd_addr  (rd_addr[o]),
         .rd_data  (rd_data[o]),
         .tx_byte  (tx_data[o*DW +: DW]),
         .tx_oe    (tx_oe[o])
      );
   end

   // processor port on the data store reads the last completed page
   assign rd_page[NSTRM] = ~wpage;
   assign rd_addr[NSTRM] = cpu_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_rdata <= '0;
      end else if (cpu_req && !cpu_we) begin
         cpu_rdata <= cpu_sel ? {{CTL_W{1'b0}}, rd_data[NSTRM]} : cpu_entry;
      end
   end

   a_r8_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_pin && !out_stby) |=> tx_oe == '0);
   a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !cpu_sel) ##1
      (cpu_req && !cpu_we && !cpu_sel && cpu_addr == $past(cpu_addr))
      |=> cpu_rdata == $past(cpu_wdata, 2));
endmodule

// File: tb/tsi_switch_core_tb_top.sv
module tsi_switch_core_tb_top;
   localparam int NS = 4, NC = 8, DW = 8, AW = 5, EW = 12;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0, frame_sync = 1'b0;
   logic [NS*DW-1:0] rx_data = '0;
   logic             oe_pin = 1'b1, out_stby = 1'b0;
   logic             cpu_req = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
   logic [AW-1:0]    cpu_addr = '0;
   logic [EW-1:0]    cpu_wdata = '0;
   logic [EW-1:0]    cpu_rdata;
   logic [NS*DW-1:0] tx_data;
   logic [NS-1:0]    tx_oe;

   tsi_switch_core #(.NSTRM(NS), .NCHAN(NC), .DW(DW)) dut_i (.*);

   int nvec = 0, nfail = 0;
   logic [EW-1:0] cm [NS*NC];
   bit run = 0, drop_sync = 0, chk_act = 0, l_chk = 0;
   int chk_left = 0, cur_f = -1, bslot = NC-1, l_f = 0, l_slot = 0;
   string cfg_tag = "R3";

   function automatic logic [7:0] inb(int f, int s, int k);
      if (f < 0) return 8'h00;
      return 8'((f*37 + s*11 + k*5 + 1) % 256);
   endfunction

   task automatic chk(string tag, logic [EW-1:0] got, logic [EW-1:0] exp);
      nvec++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %03h expected %03h", tag, got, exp);
      end
   endtask

   // frame driver and output checker
   always @(negedge clk) begin
      if (l_chk) begin
         for (int o = 0; o < NS; o++) begin
            logic [EW-1:0] e;
            logic eo;
            logic [7:0] ed;
            string tg;
            e = cm[o*NC + l_slot];
            tg = cfg_tag; eo = 1'b1; ed = 8'h00;
            if (!oe_pin && !out_stby) begin tg = "R8"; eo = 1'b0; end
            else if (e[9:8] == 2'b11) begin tg = "R7"; eo = 1'b0; end
            else if (e[11]) begin tg = "R9"; ed = inb(l_f, o, l_slot); end
            else if (e[9:8] == 2'b01) ed = e[7:0];
            else if (e[10] && int'(e[2:0]) < l_slot) ed = inb(l_f, int'(e[4:3]), int'(e[2:0]));
            else ed = inb(l_f-1, int'(e[4:3]), int'(e[2:0]));
            nvec++;
            if (tx_oe[o] !== eo || tx_data[o*DW +: DW] !== ed) begin
               nfail++;
               $display("FAIL %s stream %0d chan %0d frame %0d: got oe=%0b data=%02h expected oe=%0b data=%02h",
                        tg, o, l_slot, l_f, tx_oe[o], tx_data[o*DW +: DW], eo, ed);
            end
         end
      end
      l_chk = 1'b0;
      if (run) begin
         if (bslot == NC-1) begin bslot = 0; cur_f++; end
         else bslot++;
         frame_sync = (bslot == 0) && !drop_sync;
         if (bslot == 0) begin
            if (chk_left > 0) begin chk_act = 1'b1; chk_left--; end
            else chk_act = 1'b0;
         end
         for (int s = 0; s < NS; s++) rx_data[s*DW +: DW] = inb(cur_f, s, bslot);
         l_chk = chk_act; l_f = cur_f; l_slot = bslot;
      end
   end

   task automatic cpu_wr(bit sel, int a, logic [EW-1:0] d);
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_sel = sel; cpu_addr = AW'(a); cpu_wdata = d;
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
   endtask

   task automatic cpu_rd(bit sel, int a, output logic [EW-1:0] d, output int f);
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_sel = sel; cpu_addr = AW'(a);
      @(posedge clk);
      f = cur_f;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_req = 0;
   endtask

   task automatic load(int i, logic [EW-1:0] v);
      cm[i] = v;
      cpu_wr(0, i, v);
   endtask

   task automatic check_frames(int n);
      @(posedge clk);
      chk_left = n;
      wait (chk_left == 0);
      @(posedge clk);
      wait (chk_act == 0);
      @(posedge clk);
   endtask

   initial begin
      #(4*150000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      logic [EW-1:0] rd;
      int f;
      repeat (4) @(negedge clk);
      // R12: reset state
      chk("R12 oe in reset", EW'(tx_oe), '0);
      chk("R12 data in reset", EW'(tx_data), '0);
      rst_n = 1'b1;
      cpu_rd(0, 9, rd, f);  chk("R12 entry reset", rd, 12'h300);
      cpu_rd(1, 9, rd, f);  chk("R12 store reset", rd, 12'h000);
      run = 1;

      // R3: constant delay, cross map
      cfg_tag = "R3";
      for (int i = 0; i < NS*NC; i++)
         load(i, EW'((((i/NC)+1)%NS) << 3 | (NC-1-(i%NC))));
      check_frames(2);

      // R4: variable delay, same map
      cfg_tag = "R4";
      for (int i = 0; i < NS*NC; i++)
         load(i, EW'(12'h400 | (((i/NC)+1)%NS) << 3 | (NC-1-(i%NC))));
      check_frames(2);

      // R5: every channel fetches stream 2 channel 5
      cfg_tag = "R5";
      for (int i = 0; i < NS*NC; i++)
         load(i, EW'(((i%2) ? 12'h400 : 12'h000) | (2 << 3) | 5));
      check_frames(2);

      // R6: processor bytes, then R1 wrap without frame pulse
      cfg_tag = "R6";
      for (int i = 0; i < NS*NC; i++)
         load(i, EW'(12'h100 | (((i/NC)*40 + (i%NC) + 7) % 256)));
      check_frames(1);
      cfg_tag = "R1";
      @(posedge clk); drop_sync = 1;
      check_frames(2);
      drop_sync = 0;
      // R10: full entry readback
      for (int i = 0; i < NS*NC; i++) begin
         cpu_rd(0, i, rd, f);
         chk("R10 entry readback", rd, cm[i]);
      end

      // R7 / R9 mixed entries, R10 new entries in force
      cfg_tag = "R10";
      for (int i = 0; i < NS*NC; i++) begin
         int o, c;
         o = i / NC; c = i % NC;
         if (c % 2) load(i, 12'h300);
         else if (o == 0) load(i, EW'(12'h900 | 8'h55));
         else if (o == 1) load(i, EW'(12'h800 | (3 << 3) | 1));
         else load(i, EW'(12'h400 | (o << 3) | (NC-1-c)));
      end
      check_frames(2);

      // R8: global enable combinations
      @(negedge clk); oe_pin = 0; out_stby = 0;
      check_frames(1);
      @(negedge clk); oe_pin = 0; out_stby = 1;
      check_frames(1);
      @(negedge clk); oe_pin = 1; out_stby = 1;
      check_frames(1);
      @(negedge clk); oe_pin = 1; out_stby = 0;

      // R2: data store reads
      for (int a = 0; a < NS*NC; a++) begin
         cpu_rd(1, a, rd, f);
         chk("R2 store read", rd, EW'(inb(f-1, a/NC, a%NC)));
      end
      // R11: write to data store ignored
      for (int a = 0; a < NS*NC; a += 5) begin
         cpu_wr(1, a, 12'h0A5);
         cpu_rd(1, a, rd, f);
         chk("R11 store write ignored", rd, EW'(inb(f-1, a/NC, a%NC)));
      end

      run = 0;
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule